// File: doc/BRIEF.md
# SDR SDRAM Command Controller

This block connects a single-word host request port to a four-bank, 16-bit single-data-rate SDRAM. Each host request carries a word address, a write flag, write data and two byte enables, under a valid/ready handshake. Read results come back on a separate response port with their own valid strobe. The controller turns each request into an activate, then a single read or write with auto-precharge. It then waits for the bank to close before it takes the next request.

After reset the controller waits a configurable power-up delay. It then precharges all banks, issues two auto-refresh commands and programs the mode register with the chosen read latency. Only after that does it accept host traffic. A free-running interval counter marks a refresh as due, and the refresh is issued as soon as the access in flight has finished. All device timing gaps (activate to column, refresh cycle, bank recovery) are counted in clocks from parameters.

The host word address is split as {bank, row, column}: 2 bank bits on top, 12 row bits in the middle and 9 column bits at the bottom.

Top module: `sdr_cmd_ctrl`

## Requirements
- R1: After reset `req_ready` is low and the command lines show NOP (CS_n, RAS_n, CAS_n, WE_n = 0,1,1,1). No other command appears until at least INIT_CYC clocks after reset release.
- R2: The command encodings (CS_n, RAS_n, CAS_n, WE_n) are: ACT 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE 0000. The first four non-NOP commands are PRECHARGE with address bit 10 high, REFRESH, REFRESH and MODE. The MODE address carries CAS_LAT in bits 6:4 and zero in bits 3:0, which selects burst length 1, sequential.
- R3: No host request is accepted, and no ACT is issued, before the MODE command has been issued.
- R4: A read returns the word most recently written to the same host address. The host address maps to bank = bits 22:21, row = bits 20:9 and column = bits 8:0 on the device pins.
- R5: On a write, `sd_dqm[i]` is the inverse of `req_be[i]`; bit 1 is the upper byte. A byte whose enable is low keeps its previous contents.
- R6: Read data appears on `rsp_rdata`, with `rsp_valid` high for one cycle, exactly CAS_LAT+1 clocks after the clock edge on which the device samples the READ command.
- R7: Every READ and WRITE command carries address bit 10 high, which requests auto-precharge.
- R8: A READ or WRITE to a bank is sampled at least T_RCD clocks after the ACT that opened it.
- R9: After a REFRESH, no other command is sampled for at least T_RFC clocks. An ACT is sampled at least CAS_LAT+T_RP+1 clocks after the preceding column command.
- R10: Once initialisation is complete, consecutive REFRESH commands are at most REFI_CYC+T_RCD+CAS_LAT+T_RP+T_RFC+8 clocks apart. This holds even while the host keeps `req_valid` high without pause, because a due refresh is served before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for host port and SDRAM |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper byte |
| rsp_valid | output | 1 | Read data valid strobe |
| rsp_rdata | output | 16 | Read data |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Row / column / mode address |
| sd_dq | inout | 16 | Data bus |
| sd_dqm | output | 2 | Byte masks, bit 1 upper byte |

## Verification
The bench first writes full words to sixteen addresses that cover all four banks and distinct rows, then reads them back. A wrong field split on the address therefore shows up as a data mismatch. Partial writes with enables 01, 10 and 00 follow, each read back, which separates a mask polarity error from a lane swap. A long stream with `req_valid` held high mixes reads and writes at pseudo-random addresses. This stream checks latency alignment back to back and shows whether refresh is starved under load. An idle stretch of several refresh intervals then checks that refresh keeps running when there is no traffic.

// File: rtl/sdr_cmd_ctrl.sv
module sdr_cmd_ctrl #(
  parameter int ROW_W    = 12,
  parameter int COL_W    = 9,
  parameter int BANK_W   = 2,
  parameter int DQ_W     = 16,
  parameter int CAS_LAT  = 2,
  parameter int INIT_CYC = 20000,
  parameter int T_RCD    = 3,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 9,
  parameter int T_MRD    = 2,
  parameter int REFI_CYC = 1560,
  localparam int AW      = BANK_W + ROW_W + COL_W,
  localparam int BE_W    = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  output logic [DQ_W-1:0]   rsp_rdata,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  inout  wire  [DQ_W-1:0]   sd_dq,
  output logic [BE_W-1:0]   sd_dqm
);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [ROW_W-1:0] AP_BIT = ROW_W'(1024);
  localparam logic [ROW_W-1:0] MODE_W = ROW_W'((CAS_LAT & 7) << 4);
  localparam int REF_MAX = REFI_CYC + T_RCD + CAS_LAT + T_RP + T_RFC + 8;

  typedef enum logic [2:0] {S_POWER, S_REF1, S_REF2, S_MRS, S_IDLE, S_COL, S_WAIT} st_t;

  st_t st, nxt;
  logic [31:0]       wcnt, refc;
  logic              ref_pend;
  logic [3:0]        cmd;
  logic [BANK_W-1:0] ba_q;
  logic [ROW_W-1:0]  a_q;
  logic              dq_oe;
  logic [DQ_W-1:0]   dq_o;
  logic [BE_W-1:0]   dqm_q;
  logic              lat_wr;
  logic [COL_W-1:0]  lat_col;
  logic [DQ_W-1:0]   lat_data;
  logic [BE_W-1:0]   lat_be;
  logic [3:0]        rp;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_ba     = ba_q;
  assign sd_addr   = a_q;
  assign sd_dqm    = dqm_q;
  assign sd_dq     = dq_oe ? dq_o : 'z;
  assign req_ready = (st == S_IDLE) && !ref_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_POWER; nxt <= S_IDLE;
      wcnt <= 32'(INIT_CYC - 1); refc <= '0; ref_pend <= 1'b0;
      cmd <= C_NOP; ba_q <= '0; a_q <= '0;
      dq_oe <= 1'b0; dq_o <= '0; dqm_q <= '0;
      lat_wr <= 1'b0; lat_col <= '0; lat_data <= '0; lat_be <= '0;
      rp <= '0; rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      cmd   <= C_NOP;
      dq_oe <= 1'b0;
      dqm_q <= '0;
      rp    <= {rp[2:0], 1'b0};
      rsp_valid <= rp[CAS_LAT];
      if (rp[CAS_LAT]) rsp_rdata <= sd_dq;

      case (st)
        S_POWER: begin
          if (wcnt == 0) begin
            cmd <= C_PRE; a_q <= AP_BIT;
            wcnt <= 32'(T_RP - 1); nxt <= S_REF1; st <= S_WAIT;
          end else wcnt <= wcnt - 1;
        end
        S_REF1: begin
          cmd <= C_REF; wcnt <= 32'(T_RFC - 1); nxt <= S_REF2; st <= S_WAIT;
        end
        S_REF2: begin
          cmd <= C_REF; wcnt <= 32'(T_RFC - 1); nxt <= S_MRS; st <= S_WAIT;
        end
        S_MRS: begin
          cmd <= C_MRS; ba_q <= '0; a_q <= MODE_W;
          wcnt <= 32'(T_MRD - 1); nxt <= S_IDLE; st <= S_WAIT;
        end
        S_IDLE: begin
          if (ref_pend) begin
            cmd <= C_REF; ref_pend <= 1'b0;
            wcnt <= 32'(T_RFC - 1); nxt <= S_IDLE; st <= S_WAIT;
          end else if (req_valid) begin
            cmd      <= C_ACT;
            ba_q     <= req_addr[AW-1 -: BANK_W];
            a_q      <= req_addr[COL_W +: ROW_W];
            lat_wr   <= req_write;
            lat_col  <= req_addr[COL_W-1:0];
            lat_data <= req_wdata;
            lat_be   <= req_be;
            wcnt <= 32'(T_RCD - 1); nxt <= S_COL; st <= S_WAIT;
          end
        end
        S_COL: begin
          a_q <= AP_BIT | ROW_W'(lat_col);
          if (lat_wr) begin
            cmd <= C_WR; dq_oe <= 1'b1; dq_o <= lat_data; dqm_q <= ~lat_be;
          end else begin
            cmd <= C_RD; rp <= {rp[2:0], 1'b1};
          end
          wcnt <= 32'(CAS_LAT + T_RP); nxt <= S_IDLE; st <= S_WAIT;
        end
        S_WAIT: begin
          if (wcnt == 0) st <= nxt;
          else wcnt <= wcnt - 1;
        end
        default: st <= S_IDLE;
      endcase

      if (refc == 32'(REFI_CYC - 1)) begin
        refc <= '0; ref_pend <= 1'b1;
      end else refc <= refc + 1;
    end
  end

  logic [31:0] since_act, since_ref, since_col;
  logic        init_done;
  wire col_cmd = (cmd == C_RD) || (cmd == C_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '1; since_ref <= '1; since_col <= '1; init_done <= 1'b0;
    end else begin
      since_act <= (cmd == C_ACT) ? 32'd1 : (since_act == '1 ? since_act : since_act + 1);
      since_ref <= (cmd == C_REF) ? 32'd1 : (since_ref == '1 ? since_ref : since_ref + 1);
      since_col <= col_cmd        ? 32'd1 : (since_col == '1 ? since_col : since_col + 1);
      if (cmd == C_MRS) init_done <= 1'b1;
    end
  end

  // R3
  act_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |-> init_done);
  // R7
  col_autopre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_cmd |-> a_q[10]);
  // R8
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_cmd |-> (since_act >= 32'(T_RCD)));
  // R9
  rfc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != C_NOP) |-> (since_ref >= 32'(T_RFC)));
  // R9
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |-> (since_col >= 32'(CAS_LAT + T_RP + 1)));
  // R6
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd == C_RD, CAS_LAT + 1));
  // R10
  ref_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (since_ref <= 32'(REF_MAX)));
  // R5
  wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != C_WR) |-> (dqm_q == '0));

endmodule

// File: tb/tb_sdr_cmd_ctrl.sv
module tb_sdr_cmd_ctrl;
  localparam int CL = 3, INIT = 200, RCD = 3, RP = 3, RFC = 10, MRD = 2, REFI = 300;
  localparam int REF_MAX = REFI + RCD + CL + RP + RFC + 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  wire req_ready, rsp_valid;
  wire [15:0] rsp_rdata;
  wire sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  wire [1:0] sd_ba, sd_dqm;
  wire [11:0] sd_addr;
  wire [15:0] sd_dq;

  sdr_cmd_ctrl #(.CAS_LAT(CL), .INIT_CYC(INIT), .T_RCD(RCD), .T_RP(RP), .T_RFC(RFC),
                 .T_MRD(MRD), .REFI_CYC(REFI)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dq(sd_dq), .sd_dqm(sd_dqm));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device model
  logic [15:0] mem [int];
  logic [11:0] open_row [4];
  int t_act = -1000, t_col = -1000, t_ref = -1000, t_mrs = -1, t_first = -1;
  int last_ref = -1, n_ref_run = 0, seq = 0, rst_cyc = 0;
  logic [3:0] p = '0;
  logic [15:0] mq[$];
  int rt[$];
  logic m_drv = 0;
  logic [15:0] m_dat = '0;
  assign sd_dq = m_drv ? m_dat : 16'hzzzz;

  always @(posedge clk) begin
    logic [3:0] c;
    int key;
    bit isrd;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    isrd = 0;
    if (rst_n && c !== 4'b0111) begin
      // R1
      if (seq == 0) chk(cyc - rst_cyc >= INIT, "R1", "power-up wait", cyc - rst_cyc, INIT);
      // R9
      chk(cyc - t_ref >= RFC, "R9", "refresh cycle gap", cyc - t_ref, RFC);
      // R2
      if (seq < 4) begin
        case (seq)
          0: chk(c == 4'b0010 && sd_addr[10], "R2", "init precharge all", {sd_addr, c}, {12'h400, 4'b0010});
          1, 2: chk(c == 4'b0001, "R2", "init refresh", c, 4'b0001);
          default: chk(c == 4'b0000 && sd_addr[6:4] == CL && sd_addr[3:0] == 0, "R2", "mode word",
                       {sd_addr, c}, {12'(CL << 4), 4'b0000});
        endcase
      end
      seq++;
      case (c)
        4'b0000: t_mrs = cyc;
        4'b0011: begin
          chk(cyc - t_col >= CL + RP + 1, "R9", "activate after precharge", cyc - t_col, CL + RP + 1);
          open_row[sd_ba] = sd_addr; t_act = cyc;
        end
        4'b0101, 4'b0100: begin
          chk(sd_addr[10] === 1'b1, "R7", "auto-precharge bit", sd_addr[10], 1);
          chk(cyc - t_act >= RCD, "R8", "activate to column", cyc - t_act, RCD);
          key = int'({sd_ba, open_row[sd_ba], sd_addr[8:0]});
          t_col = cyc;
          if (c == 4'b0100) begin
            logic [15:0] o;
            o = mem.exists(key) ? mem[key] : 16'h0;
            mem[key] = {sd_dqm[1] ? o[15:8] : sd_dq[15:8], sd_dqm[0] ? o[7:0] : sd_dq[7:0]};
          end else begin
            isrd = 1; mq.push_back(mem.exists(key) ? mem[key] : 16'h0); rt.push_back(cyc);
          end
        end
        4'b0001: begin
          t_ref = cyc;
          if (t_mrs >= 0) begin
            if (last_ref >= 0)
              chk(cyc - last_ref <= REF_MAX, "R10", "refresh spacing", cyc - last_ref, REF_MAX);
            n_ref_run++;
          end
          last_ref = cyc;
        end
        default: ;
      endcase
    end
    p <= {p[2:0], isrd};
  end

  always @(negedge clk) begin
    if (p[CL-1]) begin m_drv <= 1; m_dat <= mq.pop_front(); end
    else m_drv <= 0;
  end

  // scoreboard
  logic [15:0] shadow [int];
  logic [15:0] expq[$];
  string tagq[$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) chk(0, "R4", "unexpected response", rsp_rdata, 0);
      else begin
        logic [15:0] e;
        string tg;
        int t0;
        e = expq.pop_front(); tg = tagq.pop_front();
        chk(rsp_rdata === e, tg, "read data", rsp_rdata, e);
        t0 = rt.size() ? rt.pop_front() : -100;
        chk(cyc == t0 + CL + 1, "R6", "read latency", cyc - t0, CL + 1);
      end
    end
  end

  task automatic host_op(input bit wr, input logic [22:0] a, input logic [15:0] d,
                         input logic [1:0] be, input string tg);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    if (t_first < 0) begin
      t_first = cyc;
      // R3
      chk(t_mrs >= 0 && t_first > t_mrs, "R3", "first accept after mode", t_first, t_mrs);
    end
    @(posedge clk);
    if (wr) begin
      logic [15:0] o;
      o = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
      shadow[int'(a)] = {be[1] ? d[15:8] : o[15:8], be[0] ? d[7:0] : o[7:0]};
    end else begin
      expq.push_back(shadow[int'(a)]); tagq.push_back(tg);
    end
  endtask

  task automatic idle_wait(input int n);
    @(negedge clk); req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [22:0] addr_of(input int i);
    return {2'(i), 12'((i * 37 + 5) & 12'hFFF), 9'((i * 5 + 3) & 9'h1FF)};
  endfunction

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        // R1
        chk(req_ready === 1'b0, "R1", "ready low in reset", req_ready, 0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} === 4'b0111, "R1", "NOP in reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        rst_n = 1; rst_cyc = cyc;
        @(negedge clk);
        chk(req_ready === 1'b0, "R3", "ready low during init", req_ready, 0);
        // R4: full words over all banks
        for (int i = 0; i < 16; i++) host_op(1, addr_of(i), 16'(16'h1 << i) ^ 16'(i * 16'h0F0F), 2'b11, "R4");
        for (int i = 0; i < 16; i++) host_op(0, addr_of(i), 0, 0, "R4");
        idle_wait(20);
        // R5: partial writes
        host_op(1, addr_of(1), 16'hAB12, 2'b01, "R5");
        host_op(0, addr_of(1), 0, 0, "R5");
        host_op(1, addr_of(2), 16'hCD34, 2'b10, "R5");
        host_op(0, addr_of(2), 0, 0, "R5");
        host_op(1, addr_of(3), 16'hFFFF, 2'b00, "R5");
        host_op(0, addr_of(3), 0, 0, "R5");
        // R10: streaming with valid held high
        begin
          logic [15:0] lf;
          lf = 16'hACE1;
          for (int k = 0; k < 120; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            host_op(lf[0], addr_of(int'(lf[7:4])), lf ^ 16'h5A5A, lf[3:2] | 2'b01, "R4");
          end
        end
        idle_wait(3 * REFI + 40);
        chk(expq.size() == 0, "R4", "all reads answered", expq.size(), 0);
        chk(n_ref_run >= 4, "R10", "refresh count", n_ref_run, 4);
        chk(cyc - last_ref <= REF_MAX, "R10", "refresh at end", cyc - last_ref, REF_MAX);
      end
      begin
        while (wd < 100000) begin @(posedge clk); wd++; end
        chk(0, "R10", "watchdog expired", wd, 100000);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule